// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block arbitrates 32 interrupt sources for a processor core. Each source has its own pending latch. A request pulse sets the latch. One individual enable bit per source and one global enable decide whether a pending source may be taken. Among the eligible sources, the one with the lowest index wins, because index 0 has the highest priority. The controller then hands the core a vector address. Each vector entry is eight instruction words long, so the address is a base plus eight times the index.

The controller keeps a bit vector of the interrupts that are in service. It uses this vector to enforce a nesting policy that a mode input selects. In one mode, any interrupt in service blocks every other interrupt. In the other mode, only a source of strictly higher priority than the most urgent in-service one can preempt. A return pulse from the core retires the most urgent interrupt in service. A source cannot be latched again while it is in service.

After a source is selected, the controller waits one extra slot cycle before it takes the interrupt. This slot models the one instruction that completes after the trigger. Three sources come from external pins instead of internal pulses. Each pin goes through a two-flop synchronizer and a rising-edge detector. Saving processor status and the pipeline itself are outside this block.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `pending_o`, `in_service_o` and `take_o` are all zero.
- R2: A high bit of `irq_req_i` at a clock edge sets the matching bit of `pending_o` from that edge on. The bit stays set until the source is taken.
- R3: A pending source whose `src_en_i` bit is 0, or any pending source while `glob_en_i` is 0, stays pending and is not taken. It is taken once it is enabled again.
- R4: When several sources are eligible, the one with the lowest index is taken first.
- R5: With `take_o` high, `vec_addr_o` equals the value of `vec_base_i` plus 8 times `irq_id_o`.
- R6: A source that becomes pending and eligible is taken exactly two cycles later. That gap is one selection cycle plus one slot cycle. In the cycle where `take_o` is high, the source's `pending_o` bit is 0 and its `in_service_o` bit is 1.
- R7: A request for a source whose `in_service_o` bit is set is ignored, so its `pending_o` bit stays 0.
- R8: With `nest_mode_i` = 0 (block all), no interrupt is taken while any bit of `in_service_o` is set.
- R9: With `nest_mode_i` = 1 (block lower), a pending source is taken while others are in service only if its index is below the lowest in-service index.
- R10: A pulse on `ret_i` clears only the lowest-index set bit of `in_service_o`.
- R11: External pin k drives source 9+k. A rising edge that stays stable for at least two cycles latches the source once. Keeping the pin high does not latch the source again after service.
- R12: `take_o` is a single-cycle pulse. No new interrupt is taken in the cycle right after a take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req_i | input | 32 | Internal request pulses, one per source |
| ext_irq_i | input | 3 | Asynchronous external request pins, mapped to sources 9..11 |
| src_en_i | input | 32 | Per-source enable (1 = may be taken) |
| glob_en_i | input | 1 | Global enable for all sources |
| nest_mode_i | input | 1 | 0 = service blocks all, 1 = service blocks lower and equal priority |
| ret_i | input | 1 | Return pulse, retires the most urgent in-service interrupt |
| vec_base_i | input | 24 | Base address of the vector table |
| take_o | output | 1 | One-cycle pulse when an interrupt is taken |
| irq_id_o | output | 5 | Index of the taken source |
| vec_addr_o | output | 24 | Vector address of the taken source |
| pending_o | output | 32 | Pending latches |
| in_service_o | output | 32 | In-service set |

## Verification
The bench goes after the following corner cases:

- **Priority among simultaneous requests.** Three sources are raised at once, and each one must be taken in index order, one per return. An encoder scanning the wrong way would serve the highest index first.
- **Requests for a source already in service.** The bench checks that its pending bit stays clear. A design that forgot to block these would take the interrupt a second time as soon as it returned.
- **Return in nesting mode 1.** With two nested interrupts in service, a return must clear only the more urgent one. A lower-priority request must stay queued until both are retired. A design that cleared every bit, or the wrong one, would release that request early.
- **Held external pin.** A pin kept high must fire only once. A level-sensitive design would fire continuously.
- **Disabled sources.** A source masked by its own bit or by the global enable must stay pending and fire after it is re-enabled. A design that dropped masked requests would never fire it.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    // log2 of instruction words per vector entry
    localparam int unsigned VEC_SLOT_LOG2 = 3;

    typedef enum logic {
        NEST_BLOCK_ALL   = 1'b0,
        NEST_BLOCK_LOWER = 1'b1
    } nest_mode_e;
endpackage

// File: rtl/irqc_edge_sync.sv
module irqc_edge_sync #(
    parameter int unsigned N_PINS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_i,
    output logic [N_PINS-1:0] rise_o
);
    for (genvar k = 0; k < N_PINS; k++) begin : g_pin
        logic meta_q, sync_q, prev_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= pin_i[k];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end
        assign rise_o[k] = sync_q & ~prev_q;
    end
endmodule

// File: rtl/irqc_first_set.sv
module irqc_first_set #(
    parameter int unsigned W = 32,
    localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
    parameter int unsigned NUM_SRC  = 32,
    parameter int unsigned NUM_EXT  = 3,
    parameter int unsigned EXT_BASE = 9,
    parameter int unsigned AW       = 24,
    localparam int unsigned IDW     = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req_i,
    input  logic [NUM_EXT-1:0] ext_irq_i,
    input  logic [NUM_SRC-1:0] src_en_i,
    input  logic               glob_en_i,
    input  logic               nest_mode_i,
    input  logic               ret_i,
    input  logic [AW-1:0]      vec_base_i,
    output logic               take_o,
    output logic [IDW-1:0]     irq_id_o,
    output logic [AW-1:0]      vec_addr_o,
    output logic [NUM_SRC-1:0] pending_o,
    output logic [NUM_SRC-1:0] in_service_o
);
    import irqc_pkg::*;

    typedef struct packed {
        logic [NUM_SRC-1:0] latch;
        logic [NUM_SRC-1:0] isr;
        logic               arm_v;
        logic [IDW-1:0]     arm_id;
        logic               take;
        logic [IDW-1:0]     id;
        logic [AW-1:0]      vec;
    } state_t;

    state_t st_q, st_d;

    logic [NUM_EXT-1:0] ext_rise;
    logic [NUM_SRC-1:0] ext_map, eligible, allow, take_vec, clr_vec;
    logic               sel_v, isr_v;
    logic [IDW-1:0]     sel_id, isr_top;
    nest_mode_e         mode;

    irqc_edge_sync #(.N_PINS(NUM_EXT)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_irq_i),
        .rise_o (ext_rise)
    );

    irqc_first_set #(.W(NUM_SRC)) u_pick (
        .vec_i   (eligible),
        .found_o (sel_v),
        .idx_o   (sel_id)
    );

    irqc_first_set #(.W(NUM_SRC)) u_top_isr (
        .vec_i   (st_q.isr),
        .found_o (isr_v),
        .idx_o   (isr_top)
    );

    always_comb begin
        mode    = nest_mode_e'(nest_mode_i);
        ext_map = '0;
        for (int k = 0; k < int'(NUM_EXT); k++) begin
            ext_map[EXT_BASE + k] = ext_rise[k];
        end

        // nesting gate: which indices may preempt the current service set
        for (int i = 0; i < int'(NUM_SRC); i++) begin
            if (!isr_v) begin
                allow[i] = 1'b1;
            end else if (mode == NEST_BLOCK_LOWER) begin
                allow[i] = (IDW'(i) < isr_top);
            end else begin
                allow[i] = 1'b0;
            end
        end

        eligible = st_q.latch & src_en_i & {NUM_SRC{glob_en_i}} & allow;

        take_vec = '0;
        if (st_q.arm_v) begin
            take_vec[st_q.arm_id] = 1'b1;
        end
        clr_vec = '0;
        if (ret_i && isr_v) begin
            clr_vec[isr_top] = 1'b1;
        end

        st_d       = st_q;
        st_d.take  = 1'b0;
        st_d.latch = (st_q.latch | ((irq_req_i | ext_map) & ~st_q.isr)) & ~take_vec;
        st_d.isr   = (st_q.isr & ~clr_vec) | take_vec;

        if (st_q.arm_v) begin
            // slot cycle elapsed: commit the armed source
            st_d.arm_v = 1'b0;
            st_d.take  = 1'b1;
            st_d.id    = st_q.arm_id;
            st_d.vec   = vec_base_i + (AW'(st_q.arm_id) << VEC_SLOT_LOG2);
        end else if (sel_v) begin
            st_d.arm_v  = 1'b1;
            st_d.arm_id = sel_id;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign take_o       = st_q.take;
    assign irq_id_o     = st_q.id;
    assign vec_addr_o   = st_q.vec;
    assign pending_o    = st_q.latch;
    assign in_service_o = st_q.isr;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int unsigned NUM_SRC = 32,
    localparam int unsigned IDW    = $clog2(NUM_SRC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               take_o,
    input logic [IDW-1:0]     irq_id_o,
    input logic [NUM_SRC-1:0] pending_o,
    input logic [NUM_SRC-1:0] in_service_o,
    input logic               nest_mode_i,
    input logic               ret_i
);
    logic [1:0] cyc_q;
    always_ff @(posedge clk) begin
        if (!rst_n) cyc_q <= '0;
        else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
    end

    AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o); // R12
    AST_TAKE_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> in_service_o[irq_id_o]); // R6
    AST_TAKE_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> !pending_o[irq_id_o]); // R6
    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o & in_service_o) == '0); // R7
    AST_BLOCK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 2'd2 && take_o && !$past(nest_mode_i, 2))
            |-> ($past(in_service_o, 2) == '0)); // R8
    AST_RET_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && in_service_o != '0 && !take_o && cyc_q >= 2'd1)
            |=> ($countones(in_service_o) <= $countones($past(in_service_o)))); // R10
endmodule

bind irq_prio_ctrl irqc_checker #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .take_o       (take_o),
    .irq_id_o     (irq_id_o),
    .pending_o    (pending_o),
    .in_service_o (in_service_o),
    .nest_mode_i  (nest_mode_i),
    .ret_i        (ret_i)
);

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
    localparam int N  = 32;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_req = '0;
    logic [2:0]    ext_irq = '0;
    logic [N-1:0]  src_en = '1;
    logic          glob_en = 1'b1;
    logic          nest_mode = 1'b0;
    logic          ret = 1'b0;
    logic [AW-1:0] vec_base = 24'h001000;
    logic          take;
    logic [4:0]    irq_id;
    logic [AW-1:0] vec_addr;
    logic [N-1:0]  pending, in_service;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_prio_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req), .ext_irq_i(ext_irq),
        .src_en_i(src_en), .glob_en_i(glob_en), .nest_mode_i(nest_mode),
        .ret_i(ret), .vec_base_i(vec_base), .take_o(take), .irq_id_o(irq_id),
        .vec_addr_o(vec_addr), .pending_o(pending), .in_service_o(in_service)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse(input int src);
        @(negedge clk);
        irq_req[src] = 1'b1;
        @(negedge clk);
        irq_req = '0;
    endtask

    task automatic do_ret();
        @(negedge clk);
        ret = 1'b1;
        @(negedge clk);
        ret = 1'b0;
    endtask

    task automatic wait_take(input string req, input int exp_id);
        int seen = 0;
        for (int c = 0; c < 40 && !seen; c++) begin
            @(negedge clk);
            if (take) seen = 1;
        end
        chk(req, 64'(seen), 64'd1);
        chk(req, 64'(irq_id), 64'(exp_id));
        chk("R5", 64'(vec_addr), 64'(vec_base + 24'(exp_id * 8)));
    endtask

    task automatic no_take(input string req, input int cycles);
        int seen = 0;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            if (take) seen = 1;
        end
        chk(req, 64'(seen), 64'd0);
    endtask

    task automatic t_reset();
        chk("R1", 64'(pending), 64'd0);
        chk("R1", 64'(in_service), 64'd0);
        chk("R1", 64'(take), 64'd0);
    endtask

    task automatic t_basic();
        pulse(5);
        chk("R2", 64'(pending[5]), 64'd1);
        @(negedge clk);
        chk("R6", 64'(take), 64'd0);
        @(negedge clk);
        chk("R6", 64'(take), 64'd1);
        chk("R6", 64'(irq_id), 64'd5);
        chk("R5", 64'(vec_addr), 64'h001028);
        chk("R6", 64'(pending[5]), 64'd0);
        chk("R6", 64'(in_service), 64'h20);
        @(negedge clk);
        chk("R12", 64'(take), 64'd0);
        pulse(5);
        @(negedge clk);
        chk("R7", 64'(pending[5]), 64'd0);
        do_ret();
        chk("R10", 64'(in_service), 64'd0);
        no_take("R7", 5);
    endtask

    task automatic t_priority();
        vec_base = 24'h00A000;
        @(negedge clk);
        irq_req[7] = 1'b1; irq_req[3] = 1'b1; irq_req[20] = 1'b1;
        @(negedge clk);
        irq_req = '0;
        wait_take("R4", 3);
        no_take("R8", 6);
        chk("R8", 64'(pending), 64'h00100080);
        do_ret();
        wait_take("R4", 7);
        do_ret();
        wait_take("R4", 20);
        do_ret();
    endtask

    task automatic t_mask();
        src_en[4] = 1'b0;
        pulse(4);
        no_take("R3", 6);
        chk("R3", 64'(pending[4]), 64'd1);
        src_en[4] = 1'b1;
        wait_take("R3", 4);
        do_ret();
        glob_en = 1'b0;
        pulse(2);
        no_take("R3", 6);
        chk("R3", 64'(pending[2]), 64'd1);
        glob_en = 1'b1;
        wait_take("R3", 2);
        do_ret();
    endtask

    task automatic t_nest();
        nest_mode = 1'b1;
        pulse(10);
        wait_take("R9", 10);
        pulse(12);
        no_take("R9", 6);
        pulse(6);
        wait_take("R9", 6);
        chk("R9", 64'(in_service), 64'h00000440);
        do_ret();
        chk("R10", 64'(in_service), 64'h00000400);
        no_take("R9", 5);
        chk("R9", 64'(pending[12]), 64'd1);
        do_ret();
        wait_take("R9", 12);
        do_ret();
        nest_mode = 1'b0;
    endtask

    task automatic t_ext();
        @(negedge clk);
        ext_irq[0] = 1'b1;
        wait_take("R11", 9);
        do_ret();
        no_take("R11", 10);
        chk("R11", 64'(pending[9]), 64'd0);
        ext_irq[0] = 1'b0;
        no_take("R11", 4);
        ext_irq[2] = 1'b1;
        wait_take("R11", 11);
        do_ret();
        ext_irq = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_priority();
        t_mask();
        t_nest();
        t_ext();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule